// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block runs the timeline of a successive-approximation converter. The internal clock `clk` runs at twice the converter clock rate. A phase bit splits each converter cycle into a rising half and a falling half, so the sequencer can place events on either edge. Software raises a start bit, and the sequencer waits for the next rising half before it begins a conversion. At that point it latches the channel and reference selects. It then issues a sample-and-hold strobe on a falling half. When the conversion completes, it writes the comparator-side result into a split high/low data register and raises a completion flag.

Two conversion lengths exist. A normal conversion takes 13 converter cycles. An extended conversion takes 25 converter cycles; the first conversion after enabling is always extended, and a request input can also ask for one. In single mode the start bit drops when the conversion completes. In free-running mode the next conversion begins in the same cycle as the completion, and the start bit stays high. Dropping the enable aborts all activity.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every output is low or zero: start bit, busy, strobes, completion flag, data bytes and latched selects.
- R2: A conversion begins, shown by a one-cycle `mux_latch` pulse, only in a rising half (the first `clk` cycle after enable and every second cycle after it) while idle with the start bit set, or at a free-running completion. `mux_sel_q`/`ref_sel_q` take the select inputs only at that pulse; changes during a conversion wait for the next one.
- R3: In a normal conversion, `sample_hold` pulses for one cycle 3 `clk` cycles after `mux_latch`, and `result_we` pulses 26 `clk` cycles after `mux_latch`.
- R4: In an extended conversion, `sample_hold` pulses 27 cycles and `result_we` 50 cycles after `mux_latch`. A conversion is extended when it is the first since enable or reset, or when `ext_req` is high at its start. `ext_active` is high while an extended conversion runs.
- R5: At the `result_we` cycle the result is captured and the completion flag is set on the same edge.
- R6: In single mode (`free_run` low at completion) the start bit clears on the completion edge. A `start_set` in that same cycle keeps it set.
- R7: In free-running mode with the start bit set, a new conversion begins in the completion cycle itself, and the start bit stays high.
- R8: The completion flag stays set until `flag_clr` or `irq_ack` is high for a cycle. A clear that coincides with a completion leaves the flag set.
- R9: With `en` low, any conversion aborts, `busy` and the start bit are low from the next cycle, `start_set` is ignored, and the next conversion after re-enable is extended.
- R10: `data_lo` holds result bits 7..0. `data_hi` holds result bits 9..8 in its bits 1..0, with its upper bits zero. Both bytes change only on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| start_set | input | 1 | Software write of 1 to the start bit |
| free_run | input | 1 | Free-running mode select |
| ext_req | input | 1 | Request an extended conversion |
| flag_clr | input | 1 | Software write-1-to-clear of the completion flag |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| mux_sel_in | input | 5 | Channel select from the control register |
| ref_sel_in | input | 2 | Reference select from the control register |
| sar_result | input | 10 | Result from the bit-decision datapath |
| start_bit | output | 1 | Current start bit |
| busy | output | 1 | A conversion is running |
| ext_active | output | 1 | The running conversion is extended |
| mux_latch | output | 1 | Conversion start, selects captured |
| sample_hold | output | 1 | Sample-and-hold strobe |
| result_we | output | 1 | Result write strobe |
| mux_sel_q | output | 5 | Channel select latched for this conversion |
| ref_sel_q | output | 2 | Reference select latched for this conversion |
| data_hi | output | 8 | High result byte |
| data_lo | output | 8 | Low result byte |
| irq_flag | output | 1 | Completion flag |

## Verification
The assertions check local rules on every cycle. They confirm that starts fall only in rising halves or at free-running completions, that the flag and data follow each write strobe, that clears drop the flag, that single mode drops the start bit, and that disabling empties the pipeline. They cannot show the exact spacing of 3/26 and 27/50 cycles, the choice of extended length after re-enable, or select changes made mid-conversion that do not reach the latched copies. The bench scenarios show these by comparing every output on every cycle against a behavioural timeline model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Control state held in the top-level sequencer
    typedef struct packed {
        logic start;      // software start bit
        logic first_pend; // next conversion must be extended
    } seq_ctl_t;

endpackage

// File: rtl/adc_phase_gen.sv
module adc_phase_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic rise_o
);
    typedef struct packed {
        logic phase; // 0 = rising half of converter clock, 1 = falling half
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d       = ph_q;
        ph_d.phase = en ? ~ph_q.phase : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign rise_o = en & ~ph_q.phase;

    // R2
    phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rise_o) |=> (!en || !rise_o));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int NORM_CYC     = 13,
    parameter int EXT_CYC      = 25,
    parameter int NORM_SH_HALF = 3,
    parameter int EXT_SH_HALF  = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic begin_i,
    input  logic ext_i,
    output logic busy_o,
    output logic ext_o,
    output logic sh_o,
    output logic done_o
);
    localparam int CW = $clog2(2 * EXT_CYC + 1);
    localparam logic [CW-1:0] NORM_LEN = CW'(2 * NORM_CYC);
    localparam logic [CW-1:0] EXT_LEN  = CW'(2 * EXT_CYC);
    localparam logic [CW-1:0] NORM_SH  = CW'(NORM_SH_HALF);
    localparam logic [CW-1:0] EXT_SH   = CW'(EXT_SH_HALF);

    typedef struct packed {
        logic          active;
        logic          ext;
        logic [CW-1:0] cnt;   // half-cycles elapsed since start
    } tmr_t;

    tmr_t t_d, t_q;
    logic [CW-1:0] len_c, sh_at_c;

    always_comb begin
        len_c   = t_q.ext ? EXT_LEN : NORM_LEN;
        sh_at_c = t_q.ext ? EXT_SH  : NORM_SH;
        sh_o    = en & t_q.active & (t_q.cnt == sh_at_c);
        done_o  = en & t_q.active & (t_q.cnt == len_c);

        t_d = t_q;
        if (!en) begin
            t_d = '0;
        end else if (begin_i) begin
            t_d.active = 1'b1;
            t_d.ext    = ext_i;
            t_d.cnt    = CW'(1);
        end else if (done_o) begin
            t_d.active = 1'b0;
            t_d.cnt    = '0;
        end else if (t_q.active) begin
            t_d.cnt = t_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.active;
    assign ext_o  = t_q.active & t_q.ext;

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.active |-> (t_q.cnt <= len_c));

    // R4
    sh_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_o |-> !done_o);

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy_o);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [RES_W-1:0] res_i,
    input  logic             clr_i,
    input  logic             ack_i,
    output logic [7:0]       data_hi_o,
    output logic [7:0]       data_lo_o,
    output logic             flag_o
);
    localparam int HI_W = RES_W - 8;

    typedef struct packed {
        logic             flag;
        logic [RES_W-1:0] res;
    } rr_t;

    rr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i)            r_d.res  = res_i;
        if (we_i)            r_d.flag = 1'b1;
        else if (clr_i | ack_i) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign data_lo_o = r_q.res[7:0];
    assign data_hi_o = {{(8 - HI_W){1'b0}}, r_q.res[RES_W-1:8]};
    assign flag_o    = r_q.flag;

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (flag_o && data_lo_o == $past(res_i[7:0])));

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && (clr_i || ack_i) && !we_i) |=> !flag_o);

    // R10
    stable_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(data_lo_o) && $stable(data_hi_o)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NORM_CYC     = 13,
    parameter int EXT_CYC      = 25,
    parameter int NORM_SH_HALF = 3,
    parameter int EXT_SH_HALF  = 27,
    parameter int RES_W        = 10,
    parameter int MUX_W        = 5,
    parameter int REF_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_set,
    input  logic             free_run,
    input  logic             ext_req,
    input  logic             flag_clr,
    input  logic             irq_ack,
    input  logic [MUX_W-1:0] mux_sel_in,
    input  logic [REF_W-1:0] ref_sel_in,
    input  logic [RES_W-1:0] sar_result,
    output logic             start_bit,
    output logic             busy,
    output logic             ext_active,
    output logic             mux_latch,
    output logic             sample_hold,
    output logic             result_we,
    output logic [MUX_W-1:0] mux_sel_q,
    output logic [REF_W-1:0] ref_sel_q,
    output logic [7:0]       data_hi,
    output logic [7:0]       data_lo,
    output logic             irq_flag
);
    seq_ctl_t c_d, c_q;
    logic [MUX_W-1:0] mux_d, mux_q;
    logic [REF_W-1:0] ref_d, ref_q;
    logic rise_w, busy_w, ext_w, sh_w, done_w, begin_w;

    adc_phase_gen u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .rise_o (rise_w)
    );

    adc_conv_timer #(
        .NORM_CYC     (NORM_CYC),
        .EXT_CYC      (EXT_CYC),
        .NORM_SH_HALF (NORM_SH_HALF),
        .EXT_SH_HALF  (EXT_SH_HALF)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .begin_i (begin_w),
        .ext_i   (c_q.first_pend | ext_req),
        .busy_o  (busy_w),
        .ext_o   (ext_w),
        .sh_o    (sh_w),
        .done_o  (done_w)
    );

    adc_result_reg #(.RES_W(RES_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (done_w),
        .res_i     (sar_result),
        .clr_i     (flag_clr),
        .ack_i     (irq_ack),
        .data_hi_o (data_hi),
        .data_lo_o (data_lo),
        .flag_o    (irq_flag)
    );

    always_comb begin
        begin_w = en & c_q.start & ((~busy_w & rise_w) | (done_w & free_run));

        c_d   = c_q;
        mux_d = mux_q;
        ref_d = ref_q;
        if (!en) begin
            c_d.start      = 1'b0;
            c_d.first_pend = 1'b1;
        end else begin
            if (done_w && !free_run) c_d.start = 1'b0;
            if (start_set)           c_d.start = 1'b1;
            if (begin_w) begin
                c_d.first_pend = 1'b0;
                mux_d          = mux_sel_in;
                ref_d          = ref_sel_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q   <= '{start: 1'b0, first_pend: 1'b1};
            mux_q <= '0;
            ref_q <= '0;
        end else begin
            c_q   <= c_d;
            mux_q <= mux_d;
            ref_q <= ref_d;
        end
    end

    assign start_bit   = c_q.start;
    assign busy        = busy_w;
    assign ext_active  = ext_w;
    assign mux_latch   = begin_w;
    assign sample_hold = sh_w;
    assign result_we   = done_w;
    assign mux_sel_q   = mux_q;
    assign ref_sel_q   = ref_q;

    // R2
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_latch && !busy) |-> rise_w);

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_latch |=> ($stable(mux_sel_q) && $stable(ref_sel_q)));

    // R6
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we && !free_run && !start_set) |=> !start_bit);

    // R7
    free_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_we && free_run && start_bit) |-> mux_latch);

    // R9
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !start_bit));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, start_set = 0, free_run = 0, ext_req = 0, flag_clr = 0, irq_ack = 0;
    logic [4:0] mux_sel_in = '0;
    logic [1:0] ref_sel_in = '0;
    logic [9:0] sar_result = '0;
    logic start_bit, busy, ext_active, mux_latch, sample_hold, result_we, irq_flag;
    logic [4:0] mux_sel_q;
    logic [1:0] ref_sel_q;
    logic [7:0] data_hi, data_lo;

    always #10 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set), .free_run(free_run),
        .ext_req(ext_req), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .mux_sel_in(mux_sel_in), .ref_sel_in(ref_sel_in), .sar_result(sar_result),
        .start_bit(start_bit), .busy(busy), .ext_active(ext_active), .mux_latch(mux_latch),
        .sample_hold(sample_hold), .result_we(result_we), .mux_sel_q(mux_sel_q),
        .ref_sel_q(ref_sel_q), .data_hi(data_hi), .data_lo(data_lo), .irq_flag(irq_flag)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit fin = 0;

    // behavioural timeline model
    int  m_elapsed = 0;        // half cycles since conversion start, 0 when idle
    bit  m_run = 0, m_long = 0, m_start = 0, m_flag = 0, m_fresh = 1, m_half = 0;
    int  m_res = 0, m_mux = 0, m_ref = 0;
    int  n_begin = 0, n_done = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int end_at(bit lng); return lng ? 50 : 26; endfunction
    function automatic int sh_at(bit lng);  return lng ? 27 : 3;  endfunction

    // Compare all outputs against the model, then advance one clock.
    task automatic step();
        bit e_rise, e_done, e_sh, e_begin;
        sar_result = 10'((cyc * 37 + 5) % 1024);
        #4;
        e_rise  = en && !m_half;
        e_done  = en && m_run && (m_elapsed == end_at(m_long));
        e_sh    = en && m_run && (m_elapsed == sh_at(m_long));
        e_begin = en && m_start && ((!m_run && e_rise) || (e_done && free_run));
        chk(mux_latch == e_begin, "R2", "mux_latch", int'(mux_latch), int'(e_begin));
        chk(mux_sel_q == 5'(m_mux) && ref_sel_q == 2'(m_ref), "R2", "latched selects",
            int'({mux_sel_q, ref_sel_q}), (m_mux << 2) | m_ref);
        chk(sample_hold == e_sh, m_long ? "R4" : "R3", "sample_hold", int'(sample_hold), int'(e_sh));
        chk(result_we == e_done, m_long ? "R4" : "R3", "result_we", int'(result_we), int'(e_done));
        chk(ext_active == (m_run && m_long), "R4", "ext_active", int'(ext_active), int'(m_run && m_long));
        chk(busy == m_run, "R9", "busy", int'(busy), int'(m_run));
        chk(start_bit == m_start, "R6", "start_bit", int'(start_bit), int'(m_start));
        chk(irq_flag == m_flag, "R8", "irq_flag", int'(irq_flag), int'(m_flag));
        chk(data_lo == 8'(m_res) && data_hi == 8'(m_res >> 8), "R10", "data bytes",
            int'({data_hi, data_lo}), ((m_res >> 8) << 8) | (m_res & 255));
        @(posedge clk);
        if (e_begin) n_begin++;
        if (e_done)  n_done++;
        if (e_done) m_res = int'(sar_result);
        m_flag = e_done ? 1'b1 : (m_flag && !(flag_clr || irq_ack));
        if (!en) begin
            m_half = 0; m_run = 0; m_elapsed = 0; m_start = 0; m_fresh = 1;
        end else begin
            m_half = !m_half;
            if (e_begin) begin
                m_run = 1; m_elapsed = 1; m_long = m_fresh || ext_req; m_fresh = 0;
                m_mux = int'(mux_sel_in); m_ref = int'(ref_sel_in);
            end else if (e_done) begin
                m_run = 0; m_elapsed = 0;
            end else if (m_run) m_elapsed++;
            if (e_done && !free_run) m_start = 0;
            if (start_set) m_start = 1;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_start();
        start_set = 1; step(); start_set = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!start_bit && !busy && !irq_flag && !mux_latch && !sample_hold && !result_we,
            "R1", "control outputs", int'({start_bit, busy, irq_flag}), 0);
        chk(data_hi == 0 && data_lo == 0 && mux_sel_q == 0 && ref_sel_q == 0,
            "R1", "data/selects", int'({data_hi, data_lo}), 0);
        rst_n = 1;
        @(negedge clk);

        // first conversion after enable: extended (R4), select change mid-run (R2)
        en = 1; mux_sel_in = 5'd5; ref_sel_in = 2'd1;
        pulse_start();
        run(8);
        mux_sel_in = 5'd17; ref_sel_in = 2'd3;
        run(55);
        chk(n_done == 1, "R4", "completions after first run", n_done, 1);

        // normal single conversion (R3, R5, R6), then software clear (R8)
        pulse_start();
        run(32);
        flag_clr = 1; step(); flag_clr = 0;
        run(3);

        // requested extended conversion (R4)
        ext_req = 1; pulse_start(); ext_req = 0;
        run(56);
        irq_ack = 1; step(); irq_ack = 0;

        // free-running: back-to-back conversions, start bit stays high (R7)
        free_run = 1; mux_sel_in = 5'd9;
        pulse_start();
        run(26 * 3 + 4);
        chk(start_bit == 1, "R7", "start bit while free running", int'(start_bit), 1);
        free_run = 0;
        run(30);

        // acknowledge coinciding with completion keeps the flag (R8)
        pulse_start();
        while (!(m_run && m_elapsed == end_at(m_long))) step();
        irq_ack = 1; step(); irq_ack = 0;
        chk(irq_flag == 1, "R8", "flag after coincident ack", int'(irq_flag), 1);
        run(2);

        // start write in the completion cycle keeps the start bit (R6)
        pulse_start();
        while (!(m_run && m_elapsed == end_at(m_long))) step();
        start_set = 1; step(); start_set = 0;
        chk(start_bit == 1, "R6", "start bit after coincident write", int'(start_bit), 1);
        run(30);

        // disable mid-conversion (R9): abort, start ignored, extended on re-enable
        pulse_start();
        run(10);
        en = 0; start_set = 1; run(3); start_set = 0;
        chk(busy == 0 && start_bit == 0, "R9", "idle while disabled", int'({busy, start_bit}), 0);
        en = 1; pulse_start();
        run(4);
        chk(ext_active == 1, "R9", "extended after re-enable", int'(ext_active), 1);
        run(52);

        chk(n_begin >= 11, "R7", "conversion starts seen", n_begin, 11);
        fin = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule